// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This block resolves one control-transfer instruction per clock for a 64-bit register machine whose program counter counts 64-bit instruction slots. It receives the 8-bit opcode, the 4-bit source-register field, the signed 16-bit offset, the signed 32-bit immediate, the values of the destination and source registers and the current program counter. One cycle later it reports whether control moves, the next program counter, the return address, and flags for calls, returns and undefined encodings.

Two instruction classes are handled. One compares full 64-bit operands and the other compares only their low 32 bits. Both offer equality, unsigned and signed ordering, and a bit-test predicate. The unconditional jump comes in two forms: a short form whose displacement is the 16-bit offset, and a long form whose displacement is the whole immediate. Calls and returns are only flagged. A call to a function inside the program is the one exception: it also redirects the program counter. Helper dispatch, stack frames and instruction fetch belong to the neighbouring units.

Opcode layout: bits [2:0] hold the class (5 is the 64-bit class, 6 is the 32-bit class). Bit 3 picks the second operand: 0 takes the immediate and 1 takes the source register. Bits [7:4] hold the operation code.

Top module: `brj_resolver`

## Requirements
- R1: Results appear on the outputs in the cycle after `issue_vld` is high, and `res_vld` is a one-cycle-delayed copy of `issue_vld`. While `rst_n` is low at a clock edge, every output clears to zero.
- R2: In class 5 the comparison uses all 64 bits, and an immediate second operand is first sign-extended to 64 bits. In class 6 only bits [31:0] of each operand are compared. Opcode bit 3 = 1 takes `src_val` as the second operand and bit 3 = 0 takes `imm`.
- R3: The unsigned and equality codes are taken when their relation of destination to second operand holds: 0x1 equal, 0x5 not equal, 0x2 greater, 0x3 greater-or-equal, 0xa less, 0xb less-or-equal.
- R4: The signed codes compare both operands as two's-complement values of the class width: 0x6 greater, 0x7 greater-or-equal, 0xc less, 0xd less-or-equal.
- R5: Code 0x4 is taken when the bitwise AND of the two operands, at the class width, is non-zero.
- R6: `res_ret_pc` is always pc+1. `res_next_pc` is pc+1+displacement when taken and pc+1 otherwise, wrapping modulo 2^PC_W. For conditional codes the displacement is the sign-extended `offset`.
- R7: Code 0x0 with a source field of 0 is always taken. In class 5 its displacement is `offset`, and in class 6 it is the sign-extended `imm`.
- R8: Code 0x8 raises `res_call`. With a source field of 0 or 2 (a helper call) it is not taken. With a source field of 1 it also raises `res_local_call` and is taken, with `imm` as the displacement.
- R9: Code 0x9 with a source field of 0 raises `res_exit` and is not taken.
- R10: Any of the following raises `res_illegal`, forces not taken and keeps `res_call` and `res_exit` low: code 0xe or 0xf, a class other than 5 or 6, a non-zero source field on code 0x0 or 0x9, or a source field above 2 on code 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Operation [7:4], operand select [3], class [2:0] |
| src_fld | input | 4 | Source-register field, also the call subtype |
| offset | input | OFF_W (16) | Signed short displacement |
| imm | input | IMM_W (32) | Signed immediate |
| dst_val | input | XLEN (64) | Destination register value |
| src_val | input | XLEN (64) | Source register value |
| pc | input | PC_W (32) | Current program counter in slots |
| res_vld | output | 1 | Result valid |
| res_taken | output | 1 | Control transfers to the computed target |
| res_next_pc | output | PC_W (32) | Program counter of the next instruction |
| res_ret_pc | output | PC_W (32) | Fall-through / return address |
| res_call | output | 1 | Instruction is a call |
| res_local_call | output | 1 | Call to a function inside the program |
| res_exit | output | 1 | Instruction is a return |
| res_illegal | output | 1 | Undefined encoding |

## Verification
The assertions check four relations on every cycle. A result that is not taken always lands on the fall-through address. An illegal encoding never raises taken, call or return. A local call is both a call and taken. A return is never taken. The validity flag also follows the issue strobe on every cycle. Whether each predicate picks the right comparison, width and signedness can only be shown by the bench scenarios. The same holds for which displacement source a jump uses and for the wrap of the program counter. These scenarios include directed cases where the signed and unsigned results differ, where the upper operand halves differ but the lower halves match, and where the program counter wraps.

// File: rtl/brj_pkg.sv
// Package brj_pkg
// Shared encodings and the decoded-instruction record for the branch
// resolver. Assumes the opcode layout {op[3:0], use_reg, class[2:0]}.
package brj_pkg;

    localparam logic [2:0] CLS_WIDE   = 3'h5;
    localparam logic [2:0] CLS_NARROW = 3'h6;

    typedef enum logic [3:0] {
        OP_JUMP  = 4'h0,
        OP_EQ    = 4'h1,
        OP_UGT   = 4'h2,
        OP_UGE   = 4'h3,
        OP_TEST  = 4'h4,
        OP_NE    = 4'h5,
        OP_SGT   = 4'h6,
        OP_SGE   = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_ULT   = 4'ha,
        OP_ULE   = 4'hb,
        OP_SLT   = 4'hc,
        OP_SLE   = 4'hd,
        OP_RSV_E = 4'he,
        OP_RSV_F = 4'hf
    } brj_op_e;

    typedef enum logic [2:0] {
        K_COND   = 3'd0,
        K_JUMP   = 3'd1,
        K_HELPER = 3'd2,
        K_LOCAL  = 3'd3,
        K_RET    = 3'd4,
        K_BAD    = 3'd5
    } brj_kind_e;

    typedef struct packed {
        logic      wide;
        logic      use_reg;
        brj_op_e   op;
        brj_kind_e kind;
    } brj_dec_t;

endpackage

// File: rtl/brj_decode.sv
// Module brj_decode
// Splits the opcode into class width, operand select and operation, and
// classifies the instruction. Assumes nothing about operand values; any
// encoding outside the defined set is classified K_BAD.
module brj_decode
    import brj_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [3:0] src_fld,
    output brj_dec_t   dec
);

    logic [2:0] cls;
    brj_op_e    op;
    logic       cls_ok;

    assign cls    = opcode[2:0];
    assign op     = brj_op_e'(opcode[7:4]);
    assign cls_ok = (cls == CLS_WIDE) || (cls == CLS_NARROW);

    // Classify the operation, checking the source field where it is fixed.
    always_comb begin
        dec.wide    = (cls == CLS_WIDE);
        dec.use_reg = opcode[3];
        dec.op      = op;
        dec.kind    = K_BAD;
        unique case (op)
            OP_JUMP: dec.kind = (src_fld == 4'd0) ? K_JUMP : K_BAD;
            OP_EQ, OP_UGT, OP_UGE, OP_TEST, OP_NE, OP_SGT, OP_SGE,
            OP_ULT, OP_ULE, OP_SLT, OP_SLE:
                     dec.kind = K_COND;
            OP_CALL: begin
                if (src_fld == 4'd1)
                    dec.kind = K_LOCAL;
                else if (src_fld == 4'd0 || src_fld == 4'd2)
                    dec.kind = K_HELPER;
                else
                    dec.kind = K_BAD;
            end
            OP_RET:  dec.kind = (src_fld == 4'd0) ? K_RET : K_BAD;
            default: dec.kind = K_BAD;
        endcase
        if (!cls_ok)
            dec.kind = K_BAD;
    end

endmodule

// File: rtl/brj_lane.sv
// Module brj_lane
// Raw relations of two W-bit operands: equality, unsigned and signed
// less-than, and non-zero bitwise AND. Purely combinational.
module brj_lane #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq,
    output logic         ult,
    output logic         slt,
    output logic         any_and
);

    // Compute every relation the predicates are built from.
    always_comb begin
        eq      = (a == b);
        ult     = (a < b);
        slt     = ($signed(a) < $signed(b));
        any_and = |(a & b);
    end

endmodule

// File: rtl/brj_compare.sv
// Module brj_compare
// Evaluates a conditional predicate at the full or half width. Both lanes
// are built side by side (generate) and the class picks one. Assumes the
// second operand has already been selected and sign-extended.
module brj_compare
    import brj_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            wide,
    input  brj_op_e         op,
    output logic            hit
);

    localparam int NLANE = 2;
    localparam int HALF  = XLEN / 2;

    logic [NLANE-1:0] l_eq, l_ult, l_slt, l_and;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF : XLEN;
        brj_lane #(.W(LW)) u_lane (
            .a       (a[LW-1:0]),
            .b       (b[LW-1:0]),
            .eq      (l_eq[g]),
            .ult     (l_ult[g]),
            .slt     (l_slt[g]),
            .any_and (l_and[g])
        );
    end

    logic eq, ult, slt, tst;

    // Pick the lane matching the class width.
    always_comb begin
        eq  = wide ? l_eq[1]  : l_eq[0];
        ult = wide ? l_ult[1] : l_ult[0];
        slt = wide ? l_slt[1] : l_slt[0];
        tst = wide ? l_and[1] : l_and[0];
    end

    // Map the operation code onto the raw relations.
    always_comb begin
        unique case (op)
            OP_EQ:   hit = eq;
            OP_NE:   hit = !eq;
            OP_UGT:  hit = !ult && !eq;
            OP_UGE:  hit = !ult;
            OP_ULT:  hit = ult;
            OP_ULE:  hit = ult || eq;
            OP_SGT:  hit = !slt && !eq;
            OP_SGE:  hit = !slt;
            OP_SLT:  hit = slt;
            OP_SLE:  hit = slt || eq;
            OP_TEST: hit = tst;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/brj_target.sv
// Module brj_target
// Forms the fall-through and next program counters. The displacement is
// either the short offset or the immediate, sign-extended to the counter
// width; the sum wraps modulo 2^PC_W. Assumes PC_W >= OFF_W.
module brj_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    input  logic             disp_imm,
    input  logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic [PC_W-1:0]  ret_pc
);

    logic [PC_W-1:0] disp;

    // Select and widen the displacement, then add it to the fall-through.
    always_comb begin
        disp    = disp_imm ? PC_W'($signed(imm)) : PC_W'($signed(offset));
        ret_pc  = pc + PC_W'(1);
        next_pc = taken ? (ret_pc + disp) : ret_pc;
    end

endmodule

// File: rtl/brj_resolver.sv
// Module brj_resolver
// Top of the branch resolver: decodes one control-transfer instruction,
// evaluates its condition and target, and registers the result one cycle
// after issue. Synchronous active-low reset clears every output.
module brj_resolver
    import brj_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int PC_W  = 32,
    parameter int OFF_W = 16,
    parameter int IMM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [7:0]       opcode,
    input  logic [3:0]       src_fld,
    input  logic [OFF_W-1:0] offset,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [PC_W-1:0]  pc,
    output logic             res_vld,
    output logic             res_taken,
    output logic [PC_W-1:0]  res_next_pc,
    output logic [PC_W-1:0]  res_ret_pc,
    output logic             res_call,
    output logic             res_local_call,
    output logic             res_exit,
    output logic             res_illegal
);

    brj_dec_t        dec;
    logic [XLEN-1:0] opnd_b;
    logic            cond_hit;
    logic            take;
    logic            disp_imm;
    logic [PC_W-1:0] nxt, ret;

    brj_decode u_dec (
        .opcode  (opcode),
        .src_fld (src_fld),
        .dec     (dec)
    );

    // Second operand: register or sign-extended immediate.
    assign opnd_b = dec.use_reg ? src_val : XLEN'($signed(imm));

    brj_compare #(.XLEN(XLEN)) u_cmp (
        .a    (dst_val),
        .b    (opnd_b),
        .wide (dec.wide),
        .op   (dec.op),
        .hit  (cond_hit)
    );

    // Taken decision and displacement source per instruction kind.
    always_comb begin
        unique case (dec.kind)
            K_COND:  take = cond_hit;
            K_JUMP:  take = 1'b1;
            K_LOCAL: take = 1'b1;
            default: take = 1'b0;
        endcase
        disp_imm = (dec.kind == K_LOCAL) || (dec.kind == K_JUMP && !dec.wide);
    end

    brj_target #(.PC_W(PC_W), .OFF_W(OFF_W), .IMM_W(IMM_W)) u_tgt (
        .pc       (pc),
        .offset   (offset),
        .imm      (imm),
        .disp_imm (disp_imm),
        .taken    (take),
        .next_pc  (nxt),
        .ret_pc   (ret)
    );

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld        <= 1'b0;
            res_taken      <= 1'b0;
            res_next_pc    <= '0;
            res_ret_pc     <= '0;
            res_call       <= 1'b0;
            res_local_call <= 1'b0;
            res_exit       <= 1'b0;
            res_illegal    <= 1'b0;
        end else begin
            res_vld        <= issue_vld;
            res_taken      <= take;
            res_next_pc    <= nxt;
            res_ret_pc     <= ret;
            res_call       <= (dec.kind == K_HELPER) || (dec.kind == K_LOCAL);
            res_local_call <= (dec.kind == K_LOCAL);
            res_exit       <= (dec.kind == K_RET);
            res_illegal    <= (dec.kind == K_BAD);
        end
    end

    // R1: validity follows the issue strobe by one cycle.
    p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> res_vld);
    p_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> !res_vld);

    // R6: a result that is not taken falls through to the return address.
    p_fallthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_taken) |-> (res_next_pc == res_ret_pc));

    // R8: a local call is a call that transfers control.
    p_local_call_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_local_call |-> (res_call && res_taken));

    // R9: a return is flagged alone and never taken.
    p_exit_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_exit |-> (!res_taken && !res_call));

    // R10: an illegal encoding raises no other indication.
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (!res_taken && !res_call && !res_exit));

    // R10: the three kind flags exclude one another.
    p_kind_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_call, res_exit, res_illegal}));

endmodule

// File: tb/sim_brj_resolver.sv
`timescale 1ns/1ps
module sim_brj_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [7:0]  opcode = '0;
    logic [3:0]  src_fld = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] pc = '0;
    logic        res_vld, res_taken, res_call, res_local_call, res_exit, res_illegal;
    logic [31:0] res_next_pc, res_ret_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    brj_resolver u0 (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .opcode(opcode),
        .src_fld(src_fld), .offset(offset), .imm(imm), .dst_val(dst_val),
        .src_val(src_val), .pc(pc), .res_vld(res_vld), .res_taken(res_taken),
        .res_next_pc(res_next_pc), .res_ret_pc(res_ret_pc), .res_call(res_call),
        .res_local_call(res_local_call), .res_exit(res_exit), .res_illegal(res_illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference model written from the requirements.
    task automatic ref_model(input logic [7:0] op, input logic [3:0] sf,
                             input logic [15:0] off, input logic [31:0] im,
                             input logic [63:0] dv, input logic [63:0] sv,
                             input logic [31:0] p,
                             output bit tk, output bit cl, output bit lc,
                             output bit ex, output bit il,
                             output logic [31:0] nx, output logic [31:0] rt,
                             output string req);
        logic [2:0]  cls = op[2:0];
        logic [3:0]  cd  = op[7:4];
        bit          w   = (cls == 3'd5);
        logic [63:0] b64 = op[3] ? sv : {{32{im[31]}}, im};
        logic [63:0] ua, ub;
        bit          eq, ul, sl;
        logic [31:0] disp;
        tk = 0; cl = 0; lc = 0; ex = 0; il = 0;
        disp = {{16{off[15]}}, off};
        if (w) begin
            ua = dv; ub = b64;
            sl = $signed(dv) < $signed(b64);
        end else begin
            ua = {32'd0, dv[31:0]}; ub = {32'd0, b64[31:0]};
            sl = $signed(dv[31:0]) < $signed(b64[31:0]);
        end
        eq = (ua == ub); ul = (ua < ub);
        req = "R3";
        if (cls != 3'd5 && cls != 3'd6) begin il = 1; req = "R10"; end
        else case (cd)
            4'h1: tk = eq;
            4'h5: tk = !eq;
            4'h2: tk = !ul && !eq;
            4'h3: tk = !ul;
            4'ha: tk = ul;
            4'hb: tk = ul || eq;
            4'h6: begin tk = !sl && !eq; req = "R4"; end
            4'h7: begin tk = !sl;        req = "R4"; end
            4'hc: begin tk = sl;         req = "R4"; end
            4'hd: begin tk = sl || eq;   req = "R4"; end
            4'h4: begin tk = ((ua & ub) != 0); req = "R5"; end
            4'h0: begin
                req = "R7";
                if (sf != 0) begin il = 1; req = "R10"; end
                else begin tk = 1; if (!w) disp = im; end
            end
            4'h8: begin
                req = "R8";
                if (sf == 1) begin tk = 1; cl = 1; lc = 1; disp = im; end
                else if (sf == 0 || sf == 2) cl = 1;
                else begin il = 1; req = "R10"; end
            end
            4'h9: begin
                req = "R9";
                if (sf == 0) ex = 1; else begin il = 1; req = "R10"; end
            end
            default: begin il = 1; req = "R10"; end
        endcase
        rt = p + 32'd1;
        nx = tk ? rt + disp : rt;
    endtask

    // Issue one instruction, wait for the registered result, compare all outputs.
    task automatic run(input logic [7:0] op, input logic [3:0] sf,
                       input logic [15:0] off, input logic [31:0] im,
                       input logic [63:0] dv, input logic [63:0] sv,
                       input logic [31:0] p);
        bit tk, cl, lc, ex, il;
        logic [31:0] nx, rt;
        string req;
        @(negedge clk);
        opcode = op; src_fld = sf; offset = off; imm = im;
        dst_val = dv; src_val = sv; pc = p; issue_vld = 1'b1;
        ref_model(op, sf, off, im, dv, sv, p, tk, cl, lc, ex, il, nx, rt, req);
        @(negedge clk);
        issue_vld = 1'b0;
        chk("R1", "vld", res_vld, 1);
        chk(req, "taken", res_taken, tk);
        chk("R6", "next_pc", res_next_pc, nx);
        chk("R6", "ret_pc", res_ret_pc, rt);
        chk(req, "call", res_call, cl);
        chk(req, "local", res_local_call, lc);
        chk(req, "exit", res_exit, ex);
        chk(req, "illegal", res_illegal, il);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset vld", res_vld, 0);
        chk("R1", "reset taken", res_taken, 0);
        chk("R1", "reset next_pc", res_next_pc, 0);
        chk("R1", "reset illegal", res_illegal, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle vld", res_vld, 0);

        // R2/R3: 64-bit equality, immediate sign-extended (imm=-1 vs all ones)
        run(8'h15, 0, 16'd5, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'd100);
        // R2: class 6 ignores upper halves
        run(8'h1E, 0, 16'd7, 0, 64'h1234_0000_AAAA_5555, 64'h9999_0000_AAAA_5555, 32'd10);
        run(8'h1D, 0, 16'd7, 0, 64'h1234_0000_AAAA_5555, 64'h9999_0000_AAAA_5555, 32'd10);
        // R3 vs R4: -1 against 1, unsigned greater, signed less
        run(8'h25, 0, 16'hFFFE, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'd50);
        run(8'h65, 0, 16'hFFFE, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 32'd50);
        run(8'hC6, 0, 16'd3, 32'd1, 64'h0000_0000_8000_0000, 0, 32'd50);
        // R5: bit test hit and miss
        run(8'h4D, 0, 16'd2, 0, 64'hF0, 64'h10, 32'd0);
        run(8'h4D, 0, 16'd2, 0, 64'hF0, 64'h0F, 32'd0);
        // R7: short jump with negative offset, long jump with immediate
        run(8'h05, 0, 16'hFFF0, 32'h0001_0000, 0, 0, 32'd1000);
        run(8'h06, 0, 16'h0004, 32'h0001_0000, 0, 0, 32'd1000);
        // R8: helper calls and local call
        run(8'h85, 0, 0, 32'd77, 0, 0, 32'd20);
        run(8'h85, 2, 0, 32'd77, 0, 0, 32'd20);
        run(8'h85, 1, 0, 32'hFFFF_FFF0, 0, 0, 32'd20);
        // R9: return
        run(8'h95, 0, 0, 0, 0, 0, 32'd8);
        // R10: illegal encodings
        run(8'h95, 3, 0, 0, 0, 0, 32'd8);
        run(8'h05, 1, 16'd4, 0, 0, 0, 32'd8);
        run(8'h85, 5, 0, 32'd1, 0, 0, 32'd8);
        run(8'hE5, 0, 16'd1, 0, 0, 0, 32'd8);
        run(8'h14, 0, 16'd1, 0, 0, 0, 32'd8);
        // R6: program counter wrap
        run(8'h55, 0, 16'd1, 0, 64'd3, 64'd3, 32'hFFFF_FFFF);
        run(8'h05, 0, 16'd2, 0, 0, 0, 32'hFFFF_FFFF);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  cls;
            logic [7:0]  op;
            logic [3:0]  sf;
            logic [63:0] dv, sv;
            logic [31:0] im;
            int sel;
            sel = $urandom % 10;
            cls = (sel < 9) ? ((sel & 1) ? 3'd5 : 3'd6) : 3'($urandom);
            op  = {4'($urandom), 1'($urandom), cls};
            sf  = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
            dv  = {$urandom, $urandom};
            case ($urandom % 3)
                0: sv = dv;
                1: sv = dv + 64'($urandom % 3) - 64'd1;
                default: sv = {$urandom, $urandom};
            endcase
            im = ($urandom % 2) ? sv[31:0] : $urandom;
            run(op, sf, 16'($urandom), im, dv, sv, $urandom);
        end
        finish_up();
    end

endmodule